// File: doc/BRIEF.md
# Programmable CRC Engine with Register Interface

This block computes a cyclic redundancy check over data that software writes through a small 32-bit register bus. Software picks the checksum width (8, 16 or 32 bits), loads a generator polynomial and a start value, and then writes data words of 8, 16 or 32 bits. Each accepted data write folds all of its valid bits into the running checksum in a single clock cycle.

Two optional transforms act on the data before it is folded in. The first reverses the bit order inside each byte. The second inverts every bit. Two optional transforms act on the checksum as it is read back, again a bit reversal and an inversion. The output transforms cover only the active checksum width. A one-cycle strobe in the control register reloads the running checksum from the start-value register.

The bus has one request per cycle, with a write enable. Read data is combinational from the address. Writes take effect at the next rising clock edge.

Top module: `crc_prog_engine`

## Requirements
- R1: After an asynchronous active-low reset, every register reads back as zero: control at byte offset 0x00, data at 0x04, start value at 0x08, checksum at 0x0C and polynomial at 0x10.
- R2: The control, data, start-value and polynomial registers read back what was last written. For control, only bits 31:24 and bit 0 are stored, and the strobe bit 1 always reads as 0.
- R3: Writing control with bit 1 set loads the start-value register into the running checksum at that clock edge. This happens whether or not the engine is enabled.
- R4: While control bit 0 is 0, writes to the data register leave the checksum unchanged.
- R5: While enabled, a data write shifts bits MSB-first into a checksum of the width set by control bits 31:30: 01 = 8 bits, 10 = 16 bits, 11 = 32 bits, and 00 = 16 bits. The generator comes from the low bits of the polynomial register. For the input "123456789" this gives 0xF4 for width 8 with polynomial 0x07 and start value 0. It gives 0x29B1 for width 16 with polynomial 0x1021 and start value 0xFFFF. It gives 0x0376E6E7 for width 32 with polynomial 0x04C11DB7 and start value 0xFFFFFFFF.
- R6: Control bits 29:28 set the number of data bits folded per write: 00 = 8, 01 = 16, 1x = 32. The folded bits are the low bits of the write data, with the most significant valid byte first. Higher bits are ignored.
- R7: Control bit 24 reverses the bit order within each byte of the write data and keeps the byte positions. Writing 0xAABBCCDD then gives the same checksum as writing 0x55DD33BB with the bit cleared.
- R8: Control bit 26 inverts the write data after any byte reversal. With bits 24 and 26 set, writing 0xAABBCCDD acts as a plain write of 0xAA22CC44.
- R9: Control bit 25 makes the checksum read the bit reversal of its active-width value. For example, a 32-bit value of 0xDD7B0F2E reads as 0x74F0DEBB, and a 16-bit value of 0x1234 reads as 0x2C48.
- R10: Control bit 27 inverts the checksum read value within the active width. Bits above the active width always read as zero.
- R11: The checksum register is read-only. Writes to offset 0x0C change neither the checksum nor any other register.
- R12: Each enabled data write changes the checksum exactly once, and the new value can be read in the next cycle. Cycles without a write leave all state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access in this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 5 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |

## Verification
On every cycle, the assertions check the register-level rules. These are that the strobe loads the start value, that a disabled or read-only write leaves the checksum alone, that idle cycles keep all state, that the strobe bit reads as zero, and that bits above an 8-bit result read as zero. The checksum arithmetic cannot be expressed as a property, so only the bench's scenarios show it. This covers the known result vectors for each width and the mixing of write lengths in one stream. It also covers the equivalences for byte reversal and inversion, the output transforms, and long random sequences compared with an independent model.

// File: rtl/crc_prog_pkg.sv
package crc_prog_pkg;
  localparam int XLEN = 32;
  localparam int AW   = 5;

  localparam logic [4:0] A_CTL  = 5'h00;
  localparam logic [4:0] A_DAT  = 5'h04;
  localparam logic [4:0] A_SEED = 5'h08;
  localparam logic [4:0] A_SUM  = 5'h0C;
  localparam logic [4:0] A_POLY = 5'h10;

  typedef enum logic [1:0] {CW_DEF = 2'b00, CW_8 = 2'b01, CW_16 = 2'b10, CW_32 = 2'b11} crc_w_e;
  typedef enum logic [1:0] {DL_8 = 2'b00, DL_16 = 2'b01, DL_32 = 2'b10, DL_32X = 2'b11} dlen_e;

  typedef struct packed {
    crc_w_e cw;
    dlen_e  dl;
    logic   out_inv;
    logic   in_inv;
    logic   out_rev;
    logic   in_rev;
    logic   en;
  } ctl_t;

  function automatic int unsigned crc_bits(crc_w_e w);
    case (w)
      CW_8:    return 8;
      CW_32:   return 32;
      default: return 16;
    endcase
  endfunction

  function automatic int unsigned data_bits(dlen_e d);
    case (d)
      DL_8:    return 8;
      DL_16:   return 16;
      default: return 32;
    endcase
  endfunction
endpackage

// File: rtl/crc_prog_in.sv
module crc_prog_in
  import crc_prog_pkg::*;
#(
  parameter int DW = XLEN
) (
  input  logic [DW-1:0] data_i,
  input  logic          rev_i,
  input  logic          inv_i,
  output logic [DW-1:0] data_o
);
  localparam int NB = DW / 8;

  logic [DW-1:0] byte_rev;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    for (genvar k = 0; k < 8; k++) begin : g_bit
      assign byte_rev[b*8+k] = data_i[b*8+7-k];
    end
  end

  logic [DW-1:0] stage;
  assign stage  = rev_i ? byte_rev : data_i;
  assign data_o = inv_i ? ~stage : stage;
endmodule

// File: rtl/crc_prog_fold.sv
module crc_prog_fold
  import crc_prog_pkg::*;
#(
  parameter int DW = XLEN
) (
  input  logic [DW-1:0] sum_i,
  input  logic [DW-1:0] poly_i,
  input  logic [DW-1:0] data_i,
  input  crc_w_e        cw_i,
  input  dlen_e         dl_i,
  output logic [DW-1:0] sum_o
);
  int unsigned   wb, nb;
  logic [DW-1:0] mask, top, st;
  logic          fb;

  // all valid bits unrolled into one combinational cone
  always_comb begin
    wb   = crc_bits(cw_i);
    nb   = data_bits(dl_i);
    mask = (wb >= DW) ? '1 : ((DW'(1) << wb) - DW'(1));
    top  = DW'(1) << (wb - 1);
    st   = sum_i & mask;
    fb   = 1'b0;
    for (int i = DW - 1; i >= 0; i--) begin
      if (i < int'(nb)) begin
        fb = ((st & top) != '0) ^ data_i[i];
        st = (st << 1) & mask;
        if (fb) st = st ^ (poly_i & mask);
      end
    end
    sum_o = st;
  end
endmodule

// File: rtl/crc_prog_out.sv
module crc_prog_out
  import crc_prog_pkg::*;
#(
  parameter int DW = XLEN
) (
  input  logic [DW-1:0] sum_i,
  input  crc_w_e        cw_i,
  input  logic          rev_i,
  input  logic          inv_i,
  output logic [DW-1:0] view_o
);
  logic [DW-1:0] full_rev;

  for (genvar k = 0; k < DW; k++) begin : g_rev
    assign full_rev[k] = sum_i[DW-1-k];
  end

  int unsigned   wb;
  logic [DW-1:0] mask, v;

  // reversing all DW bits then shifting down gives the reversal of the low wb bits
  always_comb begin
    wb   = crc_bits(cw_i);
    mask = (wb >= DW) ? '1 : ((DW'(1) << wb) - DW'(1));
    v    = rev_i ? (full_rev >> (DW - wb)) : (sum_i & mask);
    if (inv_i) v = ~v & mask;
    view_o = v;
  end
endmodule

// File: rtl/crc_prog_engine.sv
module crc_prog_engine
  import crc_prog_pkg::*;
#(
  parameter int AW = crc_prog_pkg::AW,
  parameter int DW = XLEN
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam logic [AW-1:0] L_CTL  = AW'(A_CTL);
  localparam logic [AW-1:0] L_DAT  = AW'(A_DAT);
  localparam logic [AW-1:0] L_SEED = AW'(A_SEED);
  localparam logic [AW-1:0] L_SUM  = AW'(A_SUM);
  localparam logic [AW-1:0] L_POLY = AW'(A_POLY);

  ctl_t          ctl_q;
  logic [DW-1:0] dat_q, seed_q, poly_q, sum_q;
  logic [DW-1:0] din_x, sum_next, sum_view;

  logic wr, wr_ctl, wr_dat, wr_seed, wr_poly;
  assign wr      = req_i & we_i;
  assign wr_ctl  = wr && (addr_i == L_CTL);
  assign wr_dat  = wr && (addr_i == L_DAT);
  assign wr_seed = wr && (addr_i == L_SEED);
  assign wr_poly = wr && (addr_i == L_POLY);

  crc_prog_in #(.DW(DW)) i_in (
    .data_i (wdata_i),
    .rev_i  (ctl_q.in_rev),
    .inv_i  (ctl_q.in_inv),
    .data_o (din_x)
  );

  crc_prog_fold #(.DW(DW)) i_fold (
    .sum_i  (sum_q),
    .poly_i (poly_q),
    .data_i (din_x),
    .cw_i   (ctl_q.cw),
    .dl_i   (ctl_q.dl),
    .sum_o  (sum_next)
  );

  crc_prog_out #(.DW(DW)) i_out (
    .sum_i  (sum_q),
    .cw_i   (ctl_q.cw),
    .rev_i  (ctl_q.out_rev),
    .inv_i  (ctl_q.out_inv),
    .view_o (sum_view)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q  <= '0;
      dat_q  <= '0;
      seed_q <= '0;
      poly_q <= '0;
    end else begin
      if (wr_ctl) begin
        ctl_q.cw      <= crc_w_e'(wdata_i[31:30]);
        ctl_q.dl      <= dlen_e'(wdata_i[29:28]);
        ctl_q.out_inv <= wdata_i[27];
        ctl_q.in_inv  <= wdata_i[26];
        ctl_q.out_rev <= wdata_i[25];
        ctl_q.in_rev  <= wdata_i[24];
        ctl_q.en      <= wdata_i[0];
      end
      if (wr_dat)  dat_q  <= wdata_i;
      if (wr_seed) seed_q <= wdata_i;
      if (wr_poly) poly_q <= wdata_i;
    end
  end

  // strobe is never stored; it acts on the running checksum only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  sum_q <= '0;
    else if (wr_ctl && wdata_i[1]) sum_q <= seed_q;
    else if (wr_dat && ctl_q.en)   sum_q <= sum_next;
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      L_CTL: begin
        rdata_o[31:24] = {ctl_q.cw, ctl_q.dl, ctl_q.out_inv, ctl_q.in_inv,
                          ctl_q.out_rev, ctl_q.in_rev};
        rdata_o[0]     = ctl_q.en;
      end
      L_DAT:   rdata_o = dat_q;
      L_SEED:  rdata_o = seed_q;
      L_SUM:   rdata_o = sum_view;
      L_POLY:  rdata_o = poly_q;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/crc_prog_chk.sv
module crc_prog_chk
  import crc_prog_pkg::*;
#(
  parameter int AW = crc_prog_pkg::AW,
  parameter int DW = XLEN
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic          we_i,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] wdata_i,
  input logic [DW-1:0] rdata_o,
  input logic [DW-1:0] sum_q,
  input logic [DW-1:0] seed_q,
  input logic [DW-1:0] poly_q,
  input logic          en_q,
  input crc_w_e        cw_q
);
  AST_STROBE_LOADS_SEED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == AW'(A_CTL) && wdata_i[1]) |=> (sum_q == $past(seed_q))); // R3

  AST_DISABLED_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == AW'(A_DAT) && !en_q) |=> $stable(sum_q)); // R4

  AST_SUM_READ_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == AW'(A_SUM)) |=> ($stable(sum_q) && $stable(seed_q) && $stable(poly_q))); // R11

  AST_IDLE_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i) |=> ($stable(sum_q) && $stable(seed_q) && $stable(poly_q))); // R12

  AST_STROBE_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == AW'(A_CTL)) |-> !rdata_o[1]); // R2

  AST_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == AW'(A_SUM) && cw_q == CW_8) |-> (rdata_o[DW-1:8] == '0)); // R10
endmodule

bind crc_prog_engine crc_prog_chk #(.AW(AW), .DW(DW)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .sum_q   (sum_q),
  .seed_q  (seed_q),
  .poly_q  (poly_q),
  .en_q    (ctl_q.en),
  .cw_q    (ctl_q.cw)
);

// File: tb/test_crc_prog_engine.sv
module test_crc_prog_engine;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int total = 0, bad = 0;
  logic [31:0] m_ctl = 0, m_dat = 0, m_seed = 0, m_poly = 0, m_sum = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crc_prog_engine i_crc_prog_engine (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
  );

  function automatic int wbits(logic [31:0] c);
    return (c[31:30] == 2'b01) ? 8 : (c[31:30] == 2'b11) ? 32 : 16;
  endfunction

  function automatic logic [31:0] ref_fold(logic [31:0] s, logic [31:0] p, logic [31:0] d, logic [31:0] c);
    int w, n;
    logic [31:0] x;
    logic m;
    w = wbits(c);
    n = (c[29:28] == 2'b00) ? 8 : (c[29:28] == 2'b01) ? 16 : 32;
    for (int b = 0; b < 4; b++)
      for (int k = 0; k < 8; k++)
        x[8*b+k] = c[24] ? d[8*b+7-k] : d[8*b+k];
    if (c[26]) x = ~x;
    for (int k = w; k < 32; k++) s[k] = 1'b0;
    for (int i = n - 1; i >= 0; i--) begin
      m = s[w-1] ^ x[i];
      s = s << 1;
      if (m) s = s ^ p;
      for (int k = w; k < 32; k++) s[k] = 1'b0;
    end
    return s;
  endfunction

  function automatic logic [31:0] ref_view(logic [31:0] s, logic [31:0] c);
    int w;
    logic [31:0] r;
    w = wbits(c);
    r = '0;
    for (int k = 0; k < w; k++) r[k] = c[25] ? s[w-1-k] : s[k];
    if (c[27]) for (int k = 0; k < w; k++) r[k] = ~r[k];
    return r;
  endfunction

  task automatic check(string req_tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%08h exp=%08h", req_tag, got, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    case (a)
      5'h00: begin
        if (d[1]) m_sum = m_seed;
        m_ctl = d & 32'hFF000001;
      end
      5'h04: begin
        m_dat = d;
        if (m_ctl[0]) m_sum = ref_fold(m_sum, m_poly, d, m_ctl);
      end
      5'h08: m_seed = d;
      5'h10: m_poly = d;
      default: ;
    endcase
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] v);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1 v = rdata;
    req = 1'b0;
  endtask

  task automatic feed9(logic [31:0] ctl_init);
    wr(5'h00, ctl_init);
    for (int i = 0; i < 9; i++) wr(5'h04, 32'hABCDEF00 | (32'h31 + i));
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog got=%08h exp=%08h", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    logic [31:0] v, a_res, b_res;
    void'($urandom(32'h00C0FFEE));
    #(CLK_PERIOD * 3);
    rst_n = 1'b1;

    // R1 reset
    for (int i = 0; i < 5; i++) begin
      rd(5'(i * 4), v);
      check("R1", v, 32'h0);
    end

    // R2 readback
    wr(5'h10, 32'h04C11DB7);
    wr(5'h08, 32'hFFFFFFFF);
    wr(5'h00, 32'hC0000003);
    rd(5'h00, v); check("R2", v, 32'hC0000001);
    rd(5'h08, v); check("R2", v, 32'hFFFFFFFF);
    rd(5'h10, v); check("R2", v, 32'h04C11DB7);
    // R3 strobe loaded seed
    rd(5'h0C, v); check("R3", v, 32'hFFFFFFFF);

    // R5 width 32, 8-bit writes with junk upper bits (R6)
    feed9(32'hC0000003);
    rd(5'h0C, v); check("R5", v, 32'h0376E6E7);
    rd(5'h04, v); check("R2", v, 32'hABCDEF39);

    // R6 mixed lengths, MSB byte first
    wr(5'h00, 32'hE0000003);
    wr(5'h04, 32'h31323334);
    wr(5'h04, 32'h35363738);
    wr(5'h00, 32'hC0000001);
    wr(5'h04, 32'h00000039);
    rd(5'h0C, v); check("R6", v, 32'h0376E6E7);
    wr(5'h00, 32'hD0000003);
    wr(5'h04, 32'hFFFF3132);
    wr(5'h04, 32'h00003334);
    wr(5'h04, 32'h12343536);
    wr(5'h04, 32'h00003738);
    wr(5'h00, 32'hC0000001);
    wr(5'h04, 32'h00000039);
    rd(5'h0C, v); check("R6", v, 32'h0376E6E7);

    // R5 width 16 and default width
    wr(5'h10, 32'h00001021);
    wr(5'h08, 32'h0000FFFF);
    feed9(32'h80000003);
    rd(5'h0C, v); check("R5", v, 32'h000029B1);
    feed9(32'h00000003);
    rd(5'h0C, v); check("R5", v, 32'h000029B1);
    // R5 width 8
    wr(5'h10, 32'h00000007);
    wr(5'h08, 32'h00000000);
    feed9(32'h40000003);
    rd(5'h0C, v); check("R5", v, 32'h000000F4);

    // R4 disabled writes
    wr(5'h00, 32'h40000000);
    wr(5'h04, 32'h00000055);
    wr(5'h04, 32'h000000AA);
    rd(5'h0C, v); check("R4", v, 32'h000000F4);

    // R11 write to checksum
    wr(5'h0C, 32'h12345678);
    rd(5'h0C, v); check("R11", v, 32'h000000F4);
    rd(5'h08, v); check("R11", v, 32'h00000000);

    // R7 byte reversal equivalence
    wr(5'h10, 32'h04C11DB7);
    wr(5'h08, 32'h89ABCDEF);
    wr(5'h00, 32'hE1000003);
    wr(5'h04, 32'hAABBCCDD);
    rd(5'h0C, a_res);
    wr(5'h00, 32'hE0000003);
    wr(5'h04, 32'h55DD33BB);
    rd(5'h0C, b_res);
    check("R7", a_res, b_res);
    check("R7", a_res, ref_fold(32'h89ABCDEF, 32'h04C11DB7, 32'h55DD33BB, 32'hE0000001));
    // R8 reversal then inversion
    wr(5'h00, 32'hE5000003);
    wr(5'h04, 32'hAABBCCDD);
    rd(5'h0C, a_res);
    wr(5'h00, 32'hE0000003);
    wr(5'h04, 32'hAA22CC44);
    rd(5'h0C, b_res);
    check("R8", a_res, b_res);

    // R9 / R10 output transforms
    wr(5'h08, 32'hDD7B0F2E);
    wr(5'h00, 32'hC2000002);
    rd(5'h0C, v); check("R9", v, 32'h74F0DEBB);
    wr(5'h00, 32'hCA000000);
    rd(5'h0C, v); check("R10", v, 32'h8B0F2144);
    wr(5'h08, 32'hFFFF1234);
    wr(5'h00, 32'h82000002);
    rd(5'h0C, v); check("R9", v, 32'h00002C48);
    wr(5'h00, 32'h8A000000);
    rd(5'h0C, v); check("R10", v, 32'h0000D3B7);
    wr(5'h00, 32'h48000000);
    rd(5'h0C, v); check("R10", v, 32'h000000CB);

    // R12 random traffic against the model
    for (int n = 0; n < 600; n++) begin
      int op;
      logic [31:0] d;
      op = $urandom_range(0, 9);
      d  = $urandom;
      case (op)
        0:       wr(5'h00, d);
        1:       wr(5'h08, d);
        2:       wr(5'h10, d);
        3:       wr(5'h0C, d);
        4:       begin rd(5'h00, v); check("R2", v, m_ctl); end
        default: wr(5'h04, d);
      endcase
      rd(5'h0C, v);
      check("R12", v, ref_view(m_sum, m_ctl));
    end
    rd(5'h04, v); check("R2", v, m_dat);
    rd(5'h08, v); check("R2", v, m_seed);
    rd(5'h10, v); check("R2", v, m_poly);

    finish_run();
  end
endmodule